// File: doc/BRIEF.md
# Trap Entry and Return MSR Unit

This is a purely combinational stage for a 64-bit processor. It covers two privileged control-flow operations: entry into the system-call handler, and return from an interrupt. The stage reads six things: an operation code, the 32-bit instruction word, the current instruction address, the current machine state register (MSR), and the two save/restore registers. The first save/restore register holds the resume address. The second holds the saved machine state.

On a system call, the stage does four things. It computes the return address. It saves a filtered copy of the MSR. It builds a new MSR with interrupts, relocation and floating-point exception modes switched off. It sends fetch to the fixed handler vector. On a return, it rebuilds the MSR from the saved state, applying asymmetric rules to each field, and sends fetch to the saved address. Each result carries its own valid flag, so a downstream writeback stage commits only the registers that the operation actually updates.

The block has no state and no handshake. Outputs follow the inputs in the same cycle. It does not accept or stall data, so there is no back-pressure rule.

Bit numbering used below: bit b counted from the MSB (b = 0 is the MSB) is LSB-index 63-b. MSR LSB-index positions are:
- HV = 60
- EE = 15
- PR = 14
- ME = 12
- FE0 = 11
- FE1 = 8
- IR = 5
- DR = 4
- RI = 1

The transaction-state field is LSB bits [34:32].

Top module: `trap_msr_unit`

## Requirements
- R1: The operation code is 0 for none, 1 for system call, 2 for return and 3 for any other operation. For codes 0 and 3, all four valid flags (`srr0_vld_o`, `srr1_vld_o`, `msr_vld_o`, `nia_vld_o`) are low.
- R2: On a system call, `srr0_o` equals `cia_i + 4` modulo 2^64 and `srr0_vld_o` is high.
- R3: On a system call, `srr1_o` LSB bits [30:27] and [21:16] are zero. All other `srr1_o` bits equal `msr_i`. `srr1_vld_o` is high.
- R4: On a system call, `msr_o` clears EE, IR, DR, FE0, FE1 and RI. Every bit other than these and HV equals `msr_i`.
- R5: On a system call, `msr_o` HV is 1 exactly when the level field `insn_i[11:5]` equals 1.
- R6: On a system call, `nia_o` is 0xC00, and `msr_vld_o` and `nia_vld_o` are high.
- R7: On a return, HV is `srr1_i` HV AND `msr_i` HV. EE, IR and DR are each the `srr1_i` bit ORed with `srr1_i` PR.
- R8: On a return, `msr_o` LSB bits [63:61], [59:35], 31, [26:22], [14:13], [11:6] and [3:0] come from `srr1_i`. LSB bits [30:27] and [21:16] keep `msr_i`.
- R9: On a return, `nia_o` is `srr0_i` with bits [1:0] zero. `msr_vld_o` and `nia_vld_o` are high, and `srr0_vld_o` and `srr1_vld_o` are low.
- R10: On a return, ME comes from `srr1_i` when `msr_i` HV is 1. Otherwise ME keeps `msr_i`.
- R11: On a return, `msr_o[34:32]` keeps `msr_i` only when `msr_i[34:32]` is 3'b010 and `srr1_i[34:32]` is 3'b000. In every other case it takes `srr1_i[34:32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation code (0 none, 1 system call, 2 return, 3 other) |
| insn_i | input | 32 | Instruction word; bits [11:5] hold the level field |
| cia_i | input | 64 | Current instruction address |
| msr_i | input | 64 | Current machine state |
| srr0_i | input | 64 | Saved resume address |
| srr1_i | input | 64 | Saved machine state |
| srr0_o | output | 64 | New resume address |
| srr0_vld_o | output | 1 | Write enable for srr0_o |
| srr1_o | output | 64 | New saved machine state |
| srr1_vld_o | output | 1 | Write enable for srr1_o |
| msr_o | output | 64 | New machine state |
| msr_vld_o | output | 1 | Write enable for msr_o |
| nia_o | output | 64 | Next instruction address |
| nia_vld_o | output | 1 | Redirect enable for nia_o |

## Verification
The bench sweeps all 128 level values, all 64 pairings of the transaction-state field, and every combination of HV and PR. It mixes these with many pseudo-random words.

Each sweep targets a specific fault:
- An address sum that does not wrap at all-ones would give a wrong resume address near the top of memory.
- A level decode that tests "nonzero" instead of "equal to one" would enter hypervisor state for every level.
- A transaction-state rule with its condition inverted or only half applied would mishandle the single suspended-to-none case.
- An ME rule keyed on the wrong HV would let a supervisor clear machine-check enable.
- A PR override wired to only some of EE, IR and DR would return to user mode with interrupts or translation off.

// File: rtl/trap_msr_pkg.sv
package trap_msr_pkg;

  localparam int XLEN   = 64;
  localparam int INSN_W = 32;

  // operation codes on the op_i port
  typedef enum logic [1:0] {
    TOP_NONE    = 2'd0,
    TOP_SYSCALL = 2'd1,
    TOP_RETURN  = 2'd2,
    TOP_OTHER   = 2'd3
  } trap_op_e;

  // machine state bit positions, LSB indexing
  localparam int MSR_HV  = 60;
  localparam int MSR_EE  = 15;
  localparam int MSR_PR  = 14;
  localparam int MSR_ME  = 12;
  localparam int MSR_FE0 = 11;
  localparam int MSR_FE1 = 8;
  localparam int MSR_IR  = 5;
  localparam int MSR_DR  = 4;
  localparam int MSR_RI  = 1;

  // transaction-state field, MSB-numbered 29..31
  localparam int TS_HI = 34;
  localparam int TS_LO = 32;

  // mask covering MSB-numbered bits s..e of an XLEN word
  function automatic logic [XLEN-1:0] be_mask(input int s, input int e);
    logic [XLEN-1:0] m;
    m = '0;
    for (int b = 0; b < XLEN; b++) begin
      if (b >= s && b <= e) m[XLEN-1-b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/trap_sc_entry.sv
module trap_sc_entry
  import trap_msr_pkg::*;
#(
  parameter int               LEV_W  = 7,
  parameter logic [XLEN-1:0]  VECTOR = 64'h0000_0000_0000_0C00,
  parameter int               STEP   = 4
) (
  input  logic [LEV_W-1:0] lev_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [XLEN-1:0]  msr_i,
  output logic [XLEN-1:0]  srr0_o,
  output logic [XLEN-1:0]  srr1_o,
  output logic [XLEN-1:0]  msr_o,
  output logic [XLEN-1:0]  nia_o
);

  // saved-state fields taken from the current MSR
  localparam logic [XLEN-1:0] SAVE_KEEP =
      be_mask(0, 32) | be_mask(37, 41) | be_mask(48, 63);

  localparam int N_CLR = 6;
  localparam int CLR_POS [N_CLR] =
      '{MSR_EE, MSR_IR, MSR_DR, MSR_FE0, MSR_FE1, MSR_RI};

  logic [XLEN-1:0] clr_mask;
  logic            hv_next;

  // mask of bits forced to zero on entry
  generate
    for (genvar g = 0; g < XLEN; g++) begin : g_clr
      localparam bit HIT = (CLR_POS[0] == g) || (CLR_POS[1] == g) ||
                           (CLR_POS[2] == g) || (CLR_POS[3] == g) ||
                           (CLR_POS[4] == g) || (CLR_POS[5] == g);
      assign clr_mask[g] = HIT;
    end
  endgenerate

  assign hv_next = (lev_i == LEV_W'(1));
  assign srr0_o  = cia_i + XLEN'(STEP);
  assign srr1_o  = msr_i & SAVE_KEEP;
  assign nia_o   = VECTOR;

  always_comb begin
    msr_o         = msr_i & ~clr_mask;
    msr_o[MSR_HV] = hv_next;
  end

  always_comb begin
    // R2
    sc_resume_chk: assert (srr0_o - cia_i == XLEN'(STEP))
      else $error("resume address not current plus step");
    // R5
    sc_level_chk: assert ((lev_i == LEV_W'(1)) ? msr_o[MSR_HV] : !msr_o[MSR_HV])
      else $error("hypervisor bit disagrees with level field");
    // R4
    sc_quiet_chk: assert (!(msr_o[MSR_EE] | msr_o[MSR_IR] | msr_o[MSR_DR] | msr_o[MSR_RI]))
      else $error("interrupt or relocation left on at entry");
  end

endmodule

// File: rtl/trap_rfid_return.sv
module trap_rfid_return
  import trap_msr_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] srr1_i,
  output logic [XLEN-1:0] msr_o
);

  // bits restored verbatim from the saved state
  localparam logic [XLEN-1:0] RESTORE =
      be_mask(0, 2) | be_mask(4, 28) | be_mask(32, 32) | be_mask(37, 41) |
      be_mask(49, 50) | be_mask(52, 57) | be_mask(60, 63);

  localparam int N_FORCE = 3;
  localparam int FORCE_POS [N_FORCE] = '{MSR_EE, MSR_IR, MSR_DR};

  logic [N_FORCE-1:0] forced;
  logic               hv_new;
  logic               me_new;
  logic [2:0]         ts_cur;
  logic [2:0]         ts_sav;
  logic [2:0]         ts_new;
  logic               ts_hold;

  // returning to problem state forces interrupts and translation on
  generate
    for (genvar g = 0; g < N_FORCE; g++) begin : g_force
      assign forced[g] = srr1_i[FORCE_POS[g]] | srr1_i[MSR_PR];
    end
  endgenerate

  assign hv_new  = srr1_i[MSR_HV] & msr_i[MSR_HV];
  assign me_new  = msr_i[MSR_HV] ? srr1_i[MSR_ME] : msr_i[MSR_ME];
  assign ts_cur  = msr_i[TS_HI:TS_LO];
  assign ts_sav  = srr1_i[TS_HI:TS_LO];
  assign ts_hold = (ts_cur == 3'b010) && (ts_sav == 3'b000);
  assign ts_new  = ts_hold ? ts_cur : ts_sav;

  always_comb begin
    msr_o = (srr1_i & RESTORE) | (msr_i & ~RESTORE);
    msr_o[MSR_HV] = hv_new;
    msr_o[MSR_ME] = me_new;
    for (int k = 0; k < N_FORCE; k++) msr_o[FORCE_POS[k]] = forced[k];
    msr_o[TS_HI:TS_LO] = ts_new;
  end

  always_comb begin
    // R7
    rf_user_chk: assert (!srr1_i[MSR_PR] ||
                         (msr_o[MSR_EE] && msr_o[MSR_IR] && msr_o[MSR_DR]))
      else $error("user return without interrupts and translation");
    // R10
    rf_mce_chk: assert (msr_i[MSR_HV] || (msr_o[MSR_ME] == msr_i[MSR_ME]))
      else $error("machine-check enable changed outside hypervisor");
    // R7
    rf_hv_chk: assert (!msr_o[MSR_HV] || (msr_i[MSR_HV] && srr1_i[MSR_HV]))
      else $error("hypervisor state gained on return");
  end

endmodule

// File: rtl/trap_msr_unit.sv
module trap_msr_unit
  import trap_msr_pkg::*;
(
  input  logic [1:0]        op_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   cia_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   srr0_i,
  input  logic [XLEN-1:0]   srr1_i,
  output logic [XLEN-1:0]   srr0_o,
  output logic              srr0_vld_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic              srr1_vld_o,
  output logic [XLEN-1:0]   msr_o,
  output logic              msr_vld_o,
  output logic [XLEN-1:0]   nia_o,
  output logic              nia_vld_o
);

  // level field: MSB-numbered instruction bits 20..26
  localparam int LEV_BE_LO = 20;
  localparam int LEV_BE_HI = 26;
  localparam int LEV_W     = LEV_BE_HI - LEV_BE_LO + 1;
  localparam int LEV_MSB   = INSN_W - 1 - LEV_BE_LO;
  localparam int LEV_LSB   = INSN_W - 1 - LEV_BE_HI;
  localparam int ALIGN     = 2;

  trap_op_e        op;
  logic            is_sc;
  logic            is_rf;
  logic [XLEN-1:0] sc_srr0;
  logic [XLEN-1:0] sc_srr1;
  logic [XLEN-1:0] sc_msr;
  logic [XLEN-1:0] sc_nia;
  logic [XLEN-1:0] rf_msr;
  logic [XLEN-1:0] rf_nia;

  logic unused_inputs;
  assign unused_inputs = ^{insn_i[INSN_W-1:LEV_MSB+1], insn_i[LEV_LSB-1:0],
                           srr0_i[ALIGN-1:0]};

  assign op    = trap_op_e'(op_i);
  assign is_sc = (op == TOP_SYSCALL);
  assign is_rf = (op == TOP_RETURN);

  trap_sc_entry #(
    .LEV_W (LEV_W)
  ) u_sc (
    .lev_i  (insn_i[LEV_MSB:LEV_LSB]),
    .cia_i  (cia_i),
    .msr_i  (msr_i),
    .srr0_o (sc_srr0),
    .srr1_o (sc_srr1),
    .msr_o  (sc_msr),
    .nia_o  (sc_nia)
  );

  trap_rfid_return u_rf (
    .msr_i  (msr_i),
    .srr1_i (srr1_i),
    .msr_o  (rf_msr)
  );

  assign rf_nia = {srr0_i[XLEN-1:ALIGN], {ALIGN{1'b0}}};

  always_comb begin
    srr0_o     = sc_srr0;
    srr1_o     = sc_srr1;
    srr0_vld_o = is_sc;
    srr1_vld_o = is_sc;
    msr_vld_o  = is_sc | is_rf;
    nia_vld_o  = is_sc | is_rf;
    msr_o      = is_rf ? rf_msr : sc_msr;
    nia_o      = is_rf ? rf_nia : sc_nia;
  end

  always_comb begin
    // R1
    idle_quiet_chk: assert (is_sc || is_rf ||
                            !(srr0_vld_o | srr1_vld_o | msr_vld_o | nia_vld_o))
      else $error("valid flag raised for an unhandled operation");
    // R9
    ret_align_chk: assert (!(is_rf && nia_vld_o) || (nia_o[ALIGN-1:0] == '0))
      else $error("return target not aligned");
    // R9
    ret_nosave_chk: assert (!is_rf || !(srr0_vld_o || srr1_vld_o))
      else $error("save registers written on return");
  end

endmodule

// File: tb/trap_msr_unit_bench.sv
module trap_msr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op;
  logic [31:0] insn;
  logic [63:0] cia, msr, srr0, srr1;
  logic [63:0] srr0_o, srr1_o, msr_o, nia_o;
  logic        srr0_v, srr1_v, msr_v, nia_v;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trap_msr_unit u_trap_msr_unit (
    .op_i(op), .insn_i(insn), .cia_i(cia), .msr_i(msr), .srr0_i(srr0), .srr1_i(srr1),
    .srr0_o(srr0_o), .srr0_vld_o(srr0_v), .srr1_o(srr1_o), .srr1_vld_o(srr1_v),
    .msr_o(msr_o), .msr_vld_o(msr_v), .nia_o(nia_o), .nia_vld_o(nia_v)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_rng(input int b, input int s, input int e);
    return (b >= s) && (b <= e);
  endfunction

  function automatic logic [63:0] bit_at(input int p);
    logic [63:0] r = '0;
    r[p] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] ref_sc_srr1(input logic [63:0] m);
    logic [63:0] r;
    for (int b = 0; b < 64; b++)
      r[63-b] = (in_rng(b, 33, 36) || in_rng(b, 42, 47)) ? 1'b0 : m[63-b];
    return r;
  endfunction

  function automatic logic [63:0] ref_sc_msr(input logic [63:0] m, input logic [31:0] w);
    logic [63:0] r = m;
    r[15] = 0; r[5] = 0; r[4] = 0; r[11] = 0; r[8] = 0; r[1] = 0;
    r[60] = (w[11:5] == 7'd1);
    return r;
  endfunction

  function automatic logic [63:0] ref_rf_msr(input logic [63:0] m, input logic [63:0] s);
    logic [63:0] r;
    for (int b = 0; b < 64; b++) begin
      if (in_rng(b, 0, 2) || in_rng(b, 4, 28) || b == 32 || in_rng(b, 37, 41) ||
          in_rng(b, 49, 50) || in_rng(b, 52, 57) || in_rng(b, 60, 63))
        r[63-b] = s[63-b];
      else
        r[63-b] = m[63-b];
    end
    r[60] = s[60] & m[60];
    r[15] = s[15] | s[14];
    r[5]  = s[5] | s[14];
    r[4]  = s[4] | s[14];
    r[12] = m[60] ? s[12] : m[12];
    if (m[34:32] == 3'b010 && s[34:32] == 3'b000) r[34:32] = m[34:32];
    else r[34:32] = s[34:32];
    return r;
  endfunction

  // apply one vector and compare every output against the reference
  task automatic apply(input logic [1:0] o, input logic [31:0] w, input logic [63:0] c,
                       input logic [63:0] m, input logic [63:0] s0, input logic [63:0] s1);
    logic [63:0] e;
    logic [63:0] hv_m, sp_m, ts_m;
    @(posedge clk);
    op = o; insn = w; cia = c; msr = m; srr0 = s0; srr1 = s1;
    @(negedge clk);
    hv_m = bit_at(60);
    sp_m = bit_at(60) | bit_at(15) | bit_at(5) | bit_at(4) | bit_at(12) | (64'h7 << 32);
    ts_m = 64'h7 << 32;
    case (o)
      2'd1: begin
        chk("R2 srr0", srr0_o, c + 64'd4);
        chk("R2 srr0 valid", {63'd0, srr0_v}, 64'd1);
        chk("R3 srr1", srr1_o, ref_sc_srr1(m));
        chk("R3 srr1 valid", {63'd0, srr1_v}, 64'd1);
        e = ref_sc_msr(m, w);
        chk("R4 msr", msr_o & ~hv_m, e & ~hv_m);
        chk("R5 hv", msr_o & hv_m, e & hv_m);
        chk("R6 nia", nia_o, 64'hC00);
        chk("R6 valids", {62'd0, msr_v, nia_v}, 64'd3);
      end
      2'd2: begin
        e = ref_rf_msr(m, s1);
        chk("R7 hv ee ir dr", msr_o & (sp_m & ~bit_at(12) & ~ts_m),
                              e & (sp_m & ~bit_at(12) & ~ts_m));
        chk("R8 copy", msr_o & ~sp_m, e & ~sp_m);
        chk("R10 me", msr_o & bit_at(12), e & bit_at(12));
        chk("R11 ts", msr_o & ts_m, e & ts_m);
        chk("R9 nia", nia_o, {s0[63:2], 2'b00});
        chk("R9 valids", {60'd0, srr0_v, srr1_v, msr_v, nia_v}, 64'd3);
      end
      default: begin
        chk("R1 valids", {60'd0, srr0_v, srr1_v, msr_v, nia_v}, 64'd0);
      end
    endcase
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    op = 2'd0; insn = '0; cia = '0; msr = '0; srr0 = '0; srr1 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: idle op gives no valid flag
    chk("R1 reset", {60'd0, srr0_v, srr1_v, msr_v, nia_v}, 64'd0);

    // R1 idle and other operation codes
    for (int i = 0; i < 200; i++)
      apply((i % 2 == 0) ? 2'd0 : 2'd3, $urandom(), rnd64(), rnd64(), rnd64(), rnd64());

    // R2 wrap corner
    apply(2'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, rnd64(), rnd64(), rnd64());
    apply(2'd1, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0);

    // R5 all level values with random state
    for (int l = 0; l < 128; l++)
      apply(2'd1, ($urandom() & ~32'h0000_0FE0) | (32'(l) << 5), rnd64(), rnd64(), rnd64(), rnd64());

    // R11 all transaction-state pairs, R7 and R10 all HV/PR/ME pairings
    for (int t = 0; t < 64; t++)
      for (int h = 0; h < 16; h++) begin
        logic [63:0] m = rnd64();
        logic [63:0] s = rnd64();
        m[34:32] = 3'(t >> 3); s[34:32] = 3'(t);
        m[60] = h[0]; s[60] = h[1]; s[14] = h[2]; m[12] = h[3]; s[12] = ~h[3];
        apply(2'd2, $urandom(), rnd64(), m, rnd64(), s);
      end

    // R8 R9 extremes
    apply(2'd2, '0, '0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(2'd2, '0, '0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h3, 64'h0);

    // broad random mix over all codes
    for (int i = 0; i < 3000; i++)
      apply(2'($urandom()), $urandom(), rnd64(), rnd64(), rnd64(), rnd64());

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule